// File: doc/BRIEF.md
# DMA Bus-Mode Mastership Sequencer

This block decides when a multi-channel DMA engine holds the system bus and when it hands the bus back. Each channel is armed with a count of transfer units, a burst/cycle-steal mode bit and a source select. The source is either an internal level request or an active-low external request pin. The sequencer raises a bus request to the CPU-side arbiter and waits for the grant. It then runs transfer units of `UNIT_CYC` bus beats each. In cycle-steal operation it drops the bus after every unit. In burst operation it keeps the bus across units.

A channel fed by the external pin always runs in cycle-steal operation, whatever its mode bit says. Each beat of such a unit is acknowledged on that channel's strobe. A pending request on another channel makes a burst give the bus back after the current unit. When units end, the lowest-numbered requesting channel is served first. When a channel's count runs out, it pulses `done` for one cycle and disarms itself. Address generation and the data path are outside this block.

Top module: `dma_busmode_seq`

## Requirements
- R1: After a synchronous active-low reset, `bus_req`, `xfer_active`, `done`, `ext_ack` and `ch_en` are all zero.
- R2: A write (`cfg_we`) with a nonzero `cfg_count` arms channel `cfg_ch`: its `ch_en` bit goes high and the count, mode and source are loaded. A write with a zero count is ignored, and the channel stays disarmed.
- R3: `bus_req` stays high until `bus_gnt` is seen. `xfer_active` is never high while `bus_gnt` is low.
- R4: Each transfer unit keeps `xfer_active` high for exactly `UNIT_CYC` cycles. In cycle-steal operation `bus_req` drops for at least one cycle after every unit.
- R5: An internally requested channel with its burst bit set (`cfg_burst`=1) holds `bus_req` high from grant to its last unit, releasing the bus exactly once.
- R6: A channel whose source select is set (`cfg_ext`=1) is requested while its `ext_req_n` pin is low (low-level sensing, one register stage). It runs in cycle-steal operation even with the burst bit set.
- R7: During every beat of a unit served for an externally requested channel, bit `xfer_ch` of `ext_ack` is high. `ext_ack` is zero at all other times and for internally requested channels.
- R8: A channel armed with count N performs exactly N units. After the last one it pulses its `done` bit for one cycle and clears its `ch_en` bit, with `bus_req` low in that cycle.
- R9: When several armed channels request at the same decision point, the lowest-numbered one is served first.
- R10: If another channel requests during a burst, the bus is released after the current unit. The next unit serves the requesting channel, and the interrupted channel stays armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Arm strobe for one channel |
| cfg_ch | input | CH_W | Channel being armed |
| cfg_count | input | CNT_W | Number of transfer units (zero ignored) |
| cfg_burst | input | 1 | 1 = burst, 0 = cycle steal (internal source only) |
| cfg_ext | input | 1 | 1 = external pin source, 0 = internal request |
| auto_req | input | NCH | Internal level requests, one per channel |
| ext_req_n | input | NCH | External request pins, active low |
| bus_gnt | input | 1 | Bus grant from the arbiter |
| bus_req | output | 1 | Bus request to the arbiter |
| xfer_active | output | 1 | A unit beat is on the bus |
| xfer_ch | output | CH_W | Channel of the current unit |
| ext_ack | output | NCH | Per-channel acknowledge for externally requested units |
| done | output | NCH | One-cycle end-of-count pulse per channel |
| ch_en | output | NCH | Armed channels |

## Verification
The hardest situation to reach is a burst being broken by another channel. The second request has to land while a unit is already on the bus, and the count must be large enough that the burst is still running when it takes effect. The bench arms a long burst, waits until it sees a beat on the bus, and only then arms and requests a lower-numbered channel. It checks that the bus drops while the burst channel is still armed, and that the next unit belongs to the newcomer. A grant model that can be held off drives the request wait state.

// File: rtl/dma_seq_pkg.sv
// Shared types for the DMA bus-mode sequencer.
// Assumes nothing beyond IEEE 1800-2017 enums.
package dma_seq_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_XFER = 2'd2,
        ST_REL  = 2'd3
    } seq_state_e;
endpackage

// File: rtl/dma_seq_chan_bank.sv
// Per-channel state: armed flag, unit counter, mode and source bits, done pulse.
// Assumes a channel is not re-armed while it is the one being served.
module dma_seq_chan_bank #(
    parameter int NCH   = 4,
    parameter int CNT_W = 8,
    localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [CH_W-1:0]  cfg_ch,
    input  logic [CNT_W-1:0] cfg_count,
    input  logic             cfg_burst,
    input  logic             cfg_ext,
    input  logic             unit_end,
    input  logic [CH_W-1:0]  cur_ch,
    output logic [NCH-1:0]   en,
    output logic [NCH-1:0]   ext_mode,
    output logic [NCH-1:0]   burst_eff,
    output logic [NCH-1:0]   last_unit,
    output logic [NCH-1:0]   done
);
    logic [CNT_W-1:0] cnt_q [NCH];
    logic [NCH-1:0]   burst_q;

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        logic sel_cfg;
        logic sel_run;
        assign sel_cfg = cfg_we && (cfg_ch == CH_W'(i)) && (cfg_count != '0);
        assign sel_run = unit_end && (cur_ch == CH_W'(i));

        // Arm, count down and disarm one channel.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                en[i]       <= 1'b0;
                cnt_q[i]    <= '0;
                burst_q[i]  <= 1'b0;
                ext_mode[i] <= 1'b0;
                done[i]     <= 1'b0;
            end else begin
                done[i] <= 1'b0;
                if (sel_cfg) begin
                    en[i]       <= 1'b1;
                    cnt_q[i]    <= cfg_count;
                    burst_q[i]  <= cfg_burst;
                    ext_mode[i] <= cfg_ext;
                end else if (sel_run) begin
                    cnt_q[i] <= cnt_q[i] - 1'b1;
                    if (cnt_q[i] == CNT_W'(1)) begin
                        en[i]   <= 1'b0;
                        done[i] <= 1'b1;
                    end
                end
            end
        end

        // Burst only applies to internally requested channels.
        assign burst_eff[i] = burst_q[i] & ~ext_mode[i];
        assign last_unit[i] = (cnt_q[i] == CNT_W'(1));
    end
endmodule

// File: rtl/dma_seq_req_sampler.sv
// Builds per-channel pending requests: registers the active-low external pins
// (low-level sensing) and selects pin or internal request by the source bit.
// Assumes the pins are already synchronous to clk.
module dma_seq_req_sampler #(
    parameter int NCH = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] auto_req,
    input  logic [NCH-1:0] ext_req_n,
    input  logic [NCH-1:0] ext_mode,
    input  logic [NCH-1:0] en,
    output logic [NCH-1:0] req_eff,
    output logic [NCH-1:0] pend
);
    logic [NCH-1:0] ext_smp_q;

    // Sample the external pins, low level means request.
    always_ff @(posedge clk) begin
        if (!rst_n) ext_smp_q <= '0;
        else        ext_smp_q <= ~ext_req_n;
    end

    // Pick the request source per channel and qualify with enable.
    always_comb begin
        req_eff = (ext_mode & ext_smp_q) | (~ext_mode & auto_req);
        pend    = req_eff & en;
    end
endmodule

// File: rtl/dma_seq_prio.sv
// Fixed-priority pick: the lowest-numbered set bit wins.
module dma_seq_prio #(
    parameter int NCH   = 4,
    localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic [NCH-1:0]  pend,
    output logic            any,
    output logic [CH_W-1:0] idx
);
    // Scan from the top so the lowest index is written last.
    always_comb begin
        idx = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (pend[i]) idx = CH_W'(i);
        end
        any = |pend;
    end
endmodule

// File: rtl/dma_busmode_seq.sv
// Bus mastership sequencer for a multi-channel DMA engine.
// Requests the bus, runs UNIT_CYC-beat transfer units, and releases the bus
// after each unit (cycle steal) or only at the end (burst).
// Assumes the arbiter drops bus_gnt once bus_req has been low for a cycle.
module dma_busmode_seq
    import dma_seq_pkg::*;
#(
    parameter int NCH      = 4,
    parameter int CNT_W    = 8,
    parameter int UNIT_CYC = 2,
    localparam int CH_W    = (NCH > 1) ? $clog2(NCH) : 1,
    localparam int BEAT_W  = (UNIT_CYC > 1) ? $clog2(UNIT_CYC) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [CH_W-1:0]  cfg_ch,
    input  logic [CNT_W-1:0] cfg_count,
    input  logic             cfg_burst,
    input  logic             cfg_ext,
    input  logic [NCH-1:0]   auto_req,
    input  logic [NCH-1:0]   ext_req_n,
    input  logic             bus_gnt,
    output logic             bus_req,
    output logic             xfer_active,
    output logic [CH_W-1:0]  xfer_ch,
    output logic [NCH-1:0]   ext_ack,
    output logic [NCH-1:0]   done,
    output logic [NCH-1:0]   ch_en
);
    seq_state_e        state_q, state_d;
    logic [CH_W-1:0]   cur_q, cur_d;
    logic [BEAT_W-1:0] beat_q, beat_d;
    logic [NCH-1:0]    en, ext_mode, burst_eff, last_unit, req_eff, pend;
    logic [NCH-1:0]    cur_oh, others;
    logic              win_any, unit_end, keep_bus;
    logic [CH_W-1:0]   win_idx;

    dma_seq_chan_bank #(.NCH(NCH), .CNT_W(CNT_W)) u_bank (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_ch(cfg_ch), .cfg_count(cfg_count),
        .cfg_burst(cfg_burst), .cfg_ext(cfg_ext),
        .unit_end(unit_end), .cur_ch(cur_q),
        .en(en), .ext_mode(ext_mode), .burst_eff(burst_eff),
        .last_unit(last_unit), .done(done)
    );

    dma_seq_req_sampler #(.NCH(NCH)) u_smp (
        .clk(clk), .rst_n(rst_n),
        .auto_req(auto_req), .ext_req_n(ext_req_n),
        .ext_mode(ext_mode), .en(en),
        .req_eff(req_eff), .pend(pend)
    );

    dma_seq_prio #(.NCH(NCH)) u_prio (
        .pend(pend), .any(win_any), .idx(win_idx)
    );

    // Decode the current channel and decide whether a burst keeps the bus.
    always_comb begin
        for (int i = 0; i < NCH; i++) cur_oh[i] = (cur_q == CH_W'(i));
        others   = pend & ~cur_oh;
        unit_end = (state_q == ST_XFER) && (beat_q == BEAT_W'(UNIT_CYC - 1));
        keep_bus = |(cur_oh & burst_eff & en & ~last_unit & req_eff) && !(|others);
    end

    // Next-state logic for request, transfer and release.
    always_comb begin
        state_d = state_q;
        cur_d   = cur_q;
        beat_d  = beat_q;
        case (state_q)
            ST_IDLE: if (win_any) state_d = ST_REQ;
            ST_REQ: begin
                if (bus_gnt) begin
                    if (win_any) begin
                        state_d = ST_XFER;
                        cur_d   = win_idx;
                        beat_d  = '0;
                    end else begin
                        state_d = ST_REL;
                    end
                end
            end
            ST_XFER: begin
                if (unit_end) begin
                    beat_d = '0;
                    if (!keep_bus) state_d = ST_REL;
                end else begin
                    beat_d = beat_q + 1'b1;
                end
            end
            ST_REL: state_d = win_any ? ST_REQ : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cur_q   <= '0;
            beat_q  <= '0;
        end else begin
            state_q <= state_d;
            cur_q   <= cur_d;
            beat_q  <= beat_d;
        end
    end

    assign bus_req     = (state_q == ST_REQ) || (state_q == ST_XFER);
    assign xfer_active = (state_q == ST_XFER);
    assign xfer_ch     = cur_q;
    assign ext_ack     = xfer_active ? (cur_oh & ext_mode) : '0;
    assign ch_en       = en;
endmodule

// File: rtl/dma_busmode_seq_chk.sv
// Protocol checker for the sequencer, bound to every instance.
module dma_busmode_seq_chk #(
    parameter int NCH = 4
) (
    input logic           clk,
    input logic           rst_n,
    input logic           bus_req,
    input logic           bus_gnt,
    input logic           xfer_active,
    input logic [NCH-1:0] ext_ack,
    input logic [NCH-1:0] done
);
    assert_beat_needs_grant_R3: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_active |-> bus_gnt);

    assert_unit_after_request_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(xfer_active) |-> $past(bus_req));

    assert_done_drops_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (|done) |-> !bus_req);

    assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(done));

    assert_ack_in_beat_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (|ext_ack) |-> (xfer_active && $onehot(ext_ack)));
endmodule

bind dma_busmode_seq dma_busmode_seq_chk #(.NCH(NCH)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_gnt(bus_gnt),
    .xfer_active(xfer_active), .ext_ack(ext_ack), .done(done)
);

// File: tb/dma_busmode_seq_bench.sv
module dma_busmode_seq_bench;
    localparam int NCH = 4, CNT_W = 8, UC = 2, CH_W = 2;

    typedef struct packed {
        logic [1:0] ch;
        logic [7:0] cnt;
        logic       burst;
        logic       ext;
        logic [7:0] rel;
    } vec_t;

    // ch, count, burst, ext, expected bus releases
    localparam vec_t TBL [5] = '{
        '{2'd0, 8'd3, 1'b0, 1'b0, 8'd3},
        '{2'd1, 8'd4, 1'b1, 1'b0, 8'd1},
        '{2'd2, 8'd2, 1'b1, 1'b1, 8'd2},
        '{2'd3, 8'd3, 1'b0, 1'b1, 8'd3},
        '{2'd1, 8'd1, 1'b1, 1'b0, 8'd1}
    };

    logic clk = 0, rst_n = 0;
    logic cfg_we = 0, cfg_burst = 0, cfg_ext = 0;
    logic [CH_W-1:0] cfg_ch = '0;
    logic [CNT_W-1:0] cfg_count = '0;
    logic [NCH-1:0] auto_req = '0, ext_req_n = '1;
    logic bus_gnt = 0, gnt_block = 0;
    logic bus_req, xfer_active;
    logic [CH_W-1:0] xfer_ch;
    logic [NCH-1:0] ext_ack, done, ch_en;

    int checks = 0, errors = 0;
    int n_xfer = 0, n_ack = 0, n_fall = 0, n_done = 0, n_nognt = 0;
    logic req_prev = 0;

    dma_busmode_seq #(.NCH(NCH), .CNT_W(CNT_W), .UNIT_CYC(UC)) u_dma_busmode_seq (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_ch(cfg_ch),
        .cfg_count(cfg_count), .cfg_burst(cfg_burst), .cfg_ext(cfg_ext),
        .auto_req(auto_req), .ext_req_n(ext_req_n), .bus_gnt(bus_gnt),
        .bus_req(bus_req), .xfer_active(xfer_active), .xfer_ch(xfer_ch),
        .ext_ack(ext_ack), .done(done), .ch_en(ch_en)
    );

    always #5 clk = ~clk;

    // Monitor at the falling edge, then model the arbiter's grant.
    initial forever begin
        @(negedge clk);
        if (xfer_active) n_xfer++;
        if (|ext_ack) n_ack++;
        if (req_prev && !bus_req) n_fall++;
        if (|done) n_done++;
        if (xfer_active && !bus_gnt) n_nognt++;
        req_prev = bus_req;
        bus_gnt  = bus_req && !gnt_block;
    end

    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not finish (actual hung, expected finish)");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic arm(input int ch, input int cnt, input logic b, input logic e);
        @(negedge clk);
        cfg_we = 1; cfg_ch = CH_W'(ch); cfg_count = CNT_W'(cnt);
        cfg_burst = b; cfg_ext = e;
        @(negedge clk);
        cfg_we = 0;
    endtask

    task automatic clr_mon();
        n_xfer = 0; n_ack = 0; n_fall = 0; n_done = 0; n_nognt = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 bus_req", int'(bus_req), 0);
        chk("R1 ch_en", int'(ch_en), 0);
        chk("R1 xfer/done/ack", int'({xfer_active, done, ext_ack}), 0);
        rst_n = 1;
        repeat (2) @(negedge clk);

        // Table walk over modes and sources
        foreach (TBL[k]) begin
            arm(int'(TBL[k].ch), int'(TBL[k].cnt), TBL[k].burst, TBL[k].ext);
            chk("R2 armed", int'(ch_en[TBL[k].ch]), 1);
            clr_mon();
            if (TBL[k].ext) ext_req_n[TBL[k].ch] = 1'b0;
            else            auto_req[TBL[k].ch] = 1'b1;
            while (ch_en[TBL[k].ch]) @(negedge clk);
            auto_req = '0; ext_req_n = '1;
            repeat (4) @(negedge clk);
            chk("R4/R8 beats", n_xfer, int'(TBL[k].cnt) * UC);
            chk(TBL[k].burst && !TBL[k].ext ? "R5 releases" : "R4/R6 releases",
                n_fall, int'(TBL[k].rel));
            chk("R7 ack beats", n_ack, TBL[k].ext ? int'(TBL[k].cnt) * UC : 0);
            chk("R8 done pulses", n_done, 1);
            chk("R3 beats without grant", n_nognt, 0);
        end

        // R2: zero count is ignored
        arm(2, 0, 1'b0, 1'b0);
        auto_req[2] = 1'b1;
        repeat (4) @(negedge clk);
        chk("R2 zero count ignored", int'(ch_en[2]), 0);
        chk("R2 zero count no request", int'(bus_req), 0);
        auto_req = '0;

        // R3: request held while grant withheld
        gnt_block = 1;
        arm(0, 1, 1'b0, 1'b0);
        auto_req[0] = 1'b1;
        repeat (10) @(negedge clk);
        chk("R3 request held", int'(bus_req), 1);
        chk("R3 no beat before grant", int'(xfer_active), 0);
        gnt_block = 0;
        while (ch_en[0]) @(negedge clk);
        auto_req = '0;
        repeat (3) @(negedge clk);

        // R9: simultaneous requests, lowest index first
        arm(2, 1, 1'b0, 1'b0);
        arm(1, 1, 1'b0, 1'b0);
        auto_req[2] = 1'b1; auto_req[1] = 1'b1;
        while (!xfer_active) @(negedge clk);
        chk("R9 lowest channel first", int'(xfer_ch), 1);
        while (ch_en[1] || ch_en[2]) @(negedge clk);
        auto_req = '0;
        repeat (3) @(negedge clk);

        // R10: burst broken by another channel
        arm(3, 6, 1'b1, 1'b0);
        auto_req[3] = 1'b1;
        while (!xfer_active) @(negedge clk);
        @(negedge clk);
        arm(0, 1, 1'b0, 1'b0);
        auto_req[0] = 1'b1;
        while (bus_req) @(negedge clk);
        chk("R10 burst channel still armed", int'(ch_en[3]), 1);
        while (!xfer_active) @(negedge clk);
        chk("R10 next unit serves requester", int'(xfer_ch), 0);
        while (ch_en[0] || ch_en[3]) @(negedge clk);
        auto_req = '0;
        repeat (3) @(negedge clk);
        chk("R8 all disarmed", int'(ch_en), 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule